// File: doc/BRIEF.md
# Strobed Handshake Port Controller

This block runs the handshake for one 8-bit data port in strobed mode. A mode write picks the direction. In input direction, a peripheral pulses a strobe low to place a byte in an input latch. The block then raises a buffer-full flag. When the strobe returns high it can also raise an interrupt request. A CPU read empties the latch. In output direction, a CPU write loads an output register and drives an active-low buffer-full flag. The peripheral's acknowledge pulse empties the buffer. The rising edge of that pulse can raise an interrupt request, and the next CPU write clears it.

The handshake lines sit on fixed bits of an 8-bit control port. Which bits depends on the direction and on the `PORT_B` parameter, which selects which of the two port positions the block serves. An interrupt-enable flip-flop gates the interrupt request. Software writes it with a single-bit set/reset command that addresses one control-port bit. Address decoding and the control word register live outside the block; they supply one-cycle read, write, mode and bit-set/reset pulses.

Top module: `hs_port`

## Requirements
- R1: After reset, the block is in input direction. Buffer-full and interrupt are 0, the active-low output-full flag is 1, the enable flip-flop is 0, `pd_oe` is 0 and `cpu_rdata` is 0.
- R2: Control-port roles. With `PORT_B`=0, input direction drives bit 5 (buffer full) and bit 3 (interrupt), so `pc_oe`=8'h28, and takes the strobe on bit 4. Output direction drives bit 7 (output full, active low) and bit 3, so `pc_oe`=8'h88, and takes the acknowledge on bit 6. With `PORT_B`=1, bit 1 is full, bit 0 is interrupt (`pc_oe`=8'h03) and bit 2 is strobe or acknowledge. No other bit is driven.
- R3: In input direction, each clock edge that sees the strobe low copies `pd_in` into the input latch and sets buffer-full. Both are visible one cycle later, with `cpu_rdata` showing the latched byte.
- R4: In input direction, the edge that first sees the strobe high again sets the interrupt if buffer-full is set and the enable flip-flop is 1. It does not set the interrupt when the enable flip-flop is 0.
- R5: In input direction, `cpu_rd` clears buffer-full and the interrupt on the next edge.
- R6: In output direction, `cpu_wr` loads `cpu_wdata` onto `pd_out`, drives the output-full flag to 0 and clears the interrupt, all one cycle later. `pd_oe` is 1 throughout output direction.
- R7: In output direction, the first edge that sees the acknowledge low sets the output-full flag back to 1.
- R8: In output direction, the first edge that sees the acknowledge high again sets the interrupt if the enable flip-flop is 1. It does not set the interrupt when the enable flip-flop is 0.
- R9: A bit set/reset command writes the enable flip-flop only when `bsr_bit` names the enable bit: 4 for input and 6 for output with `PORT_B`=0, and 2 for `PORT_B`=1. A command on any other bit has no effect on the interrupt.
- R10: `mode_wr` loads the direction from `mode_dir_in` (1 = input). It clears the enable flip-flop, buffer-full and the interrupt, sets the output-full flag to 1 and zeroes the output register.
- R11: When the strobe is low in the same cycle as `cpu_rd`, the new byte wins and buffer-full stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_wr | input | 1 | One-cycle mode write pulse |
| mode_dir_in | input | 1 | Direction for the mode write, 1 = input |
| bsr_wr | input | 1 | One-cycle bit set/reset pulse |
| bsr_bit | input | 3 | Control-port bit addressed by the set/reset |
| bsr_val | input | 1 | Value written by the set/reset |
| cpu_rd | input | 1 | One-cycle CPU read pulse for this port |
| cpu_wr | input | 1 | One-cycle CPU write pulse for this port |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | Input latch (input direction) or output register |
| pd_in | input | DW | Data port pins, sampled |
| pd_out | output | DW | Data port output value |
| pd_oe | output | 1 | Data port output enable |
| pc_in | input | 8 | Control port pins, sampled |
| pc_out | output | 8 | Control port output values for handshake roles |
| pc_oe | output | 8 | Control port output enables for handshake roles |

## Verification
The bench runs every byte value through a full input handshake and a full output handshake on both port positions at once, alternating the enable flip-flop between iterations. A design that swapped strobe edges, ignored the enable or left a stale flag would show a wrong interrupt or flag in a known cycle. It sends a bit set/reset to all eight control bits. Only the enable bit of the current role may act, so a decoder that accepted the wrong bit would raise an interrupt it should not. It also checks that a read colliding with a strobe keeps the buffer full, and that a mode write in the middle of a transfer clears the pending flags, the output data and the enable. A design that got either case wrong would lose a byte or fire a leftover interrupt.

// File: rtl/hs_port.sv
module hs_port #(
  parameter int DW     = 8,
  parameter bit PORT_B = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr,
  input  logic          mode_dir_in,
  input  logic          bsr_wr,
  input  logic [2:0]    bsr_bit,
  input  logic          bsr_val,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic [DW-1:0] pd_in,
  output logic [DW-1:0] pd_out,
  output logic          pd_oe,
  input  logic [7:0]    pc_in,
  output logic [7:0]    pc_out,
  output logic [7:0]    pc_oe
);
  localparam int STB_BIT = PORT_B ? 2 : 4;
  localparam int ACK_BIT = PORT_B ? 2 : 6;
  localparam int IBF_BIT = PORT_B ? 1 : 5;
  localparam int OBF_BIT = PORT_B ? 1 : 7;
  localparam int INT_BIT = PORT_B ? 0 : 3;
  localparam logic [2:0] EN_IN_BIT  = PORT_B ? 3'd2 : 3'd4;
  localparam logic [2:0] EN_OUT_BIT = PORT_B ? 3'd2 : 3'd6;

  logic          dir_in, inte, ibf, obf_n, intr, stb_d, ack_d;
  logic [DW-1:0] in_q, out_q;

  wire stb_n    = pc_in[STB_BIT];
  wire ack_n    = pc_in[ACK_BIT];
  wire stb_rise = dir_in & stb_n & ~stb_d;
  wire ack_fall = ~dir_in & ~ack_n & ack_d;
  wire ack_rise = ~dir_in & ack_n & ~ack_d;
  wire [2:0] en_bit = dir_in ? EN_IN_BIT : EN_OUT_BIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_in <= 1'b1;
      inte   <= 1'b0;
      ibf    <= 1'b0;
      obf_n  <= 1'b1;
      intr   <= 1'b0;
      stb_d  <= 1'b1;
      ack_d  <= 1'b1;
      in_q   <= '0;
      out_q  <= '0;
    end else begin
      stb_d <= stb_n;
      ack_d <= ack_n;
      if (mode_wr) begin
        dir_in <= mode_dir_in;
        inte   <= 1'b0;
        ibf    <= 1'b0;
        obf_n  <= 1'b1;
        intr   <= 1'b0;
        out_q  <= '0;
      end else begin
        if (bsr_wr && bsr_bit == en_bit) inte <= bsr_val;
        if (dir_in) begin
          if (cpu_rd) begin
            ibf  <= 1'b0;
            intr <= 1'b0;
          end
          if (!stb_n) begin
            in_q <= pd_in;
            ibf  <= 1'b1;
          end
          if (stb_rise && inte && ibf && !cpu_rd) intr <= 1'b1;
        end else begin
          if (ack_fall) obf_n <= 1'b1;
          if (ack_rise && inte) intr <= 1'b1;
          if (cpu_wr) begin
            out_q <= cpu_wdata;
            obf_n <= 1'b0;
            intr  <= 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    pc_out = '0;
    pc_oe  = '0;
    if (dir_in) begin
      pc_out[IBF_BIT] = ibf;
      pc_oe[IBF_BIT]  = 1'b1;
    end else begin
      pc_out[OBF_BIT] = obf_n;
      pc_oe[OBF_BIT]  = 1'b1;
    end
    pc_out[INT_BIT] = intr;
    pc_oe[INT_BIT]  = 1'b1;
  end

  assign pd_out    = out_q;
  assign pd_oe     = ~dir_in;
  assign cpu_rdata = dir_in ? in_q : out_q;
endmodule

module hs_port_chk #(
  parameter int DW     = 8,
  parameter bit PORT_B = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_wr,
  input logic          cpu_rd,
  input logic          cpu_wr,
  input logic [DW-1:0] cpu_wdata,
  input logic [DW-1:0] cpu_rdata,
  input logic [DW-1:0] pd_in,
  input logic [DW-1:0] pd_out,
  input logic [7:0]    pc_in,
  input logic [7:0]    pc_out,
  input logic          dir_in,
  input logic          inte,
  input logic          ack_d
);
  localparam int STB_BIT = PORT_B ? 2 : 4;
  localparam int ACK_BIT = PORT_B ? 2 : 6;
  localparam int IBF_BIT = PORT_B ? 1 : 5;
  localparam int OBF_BIT = PORT_B ? 1 : 7;
  localparam int INT_BIT = PORT_B ? 0 : 3;

  AST_STB_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_in && !pc_in[STB_BIT] && !mode_wr) |=> (pc_out[IBF_BIT] && cpu_rdata == $past(pd_in))); // R3
  AST_INT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pc_out[INT_BIT]) |-> $past(inte)); // R4
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_in && cpu_rd && pc_in[STB_BIT] && !mode_wr) |=> (!pc_out[IBF_BIT] && !pc_out[INT_BIT])); // R5
  AST_WR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_in && cpu_wr && !mode_wr) |=> (!pc_out[OBF_BIT] && pd_out == $past(cpu_wdata))); // R6
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_in && ack_d && !pc_in[ACK_BIT] && !cpu_wr && !mode_wr) |=> pc_out[OBF_BIT]); // R7
  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (!inte && !pc_out[INT_BIT] && pd_out == '0)); // R10
endmodule

bind hs_port hs_port_chk #(.DW(DW), .PORT_B(PORT_B)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pd_in(pd_in), .pd_out(pd_out),
  .pc_in(pc_in), .pc_out(pc_out), .dir_in(dir_in), .inte(inte), .ack_d(ack_d)
);

// File: tb/hs_port_bench.sv
module hs_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wr = 1'b0, mode_dir_in = 1'b1;
  logic       bsr_wr = 1'b0, bsr_val = 1'b0;
  logic [2:0] bsr_bit = '0;
  logic       cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0, pd_in = '0;
  logic [7:0] pcin_a = 8'hFF, pcin_b = 8'hFF;
  logic [7:0] rdata_a, rdata_b, pdo_a, pdo_b, pcout_a, pcout_b, pcoe_a, pcoe_b;
  logic       pdoe_a, pdoe_b;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  hs_port #(.DW(8), .PORT_B(1'b0)) u_hs_port (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_dir_in(mode_dir_in),
    .bsr_wr(bsr_wr), .bsr_bit(bsr_bit), .bsr_val(bsr_val), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(rdata_a), .pd_in(pd_in),
    .pd_out(pdo_a), .pd_oe(pdoe_a), .pc_in(pcin_a), .pc_out(pcout_a), .pc_oe(pcoe_a));

  hs_port #(.DW(8), .PORT_B(1'b1)) u_hs_port_b (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_dir_in(mode_dir_in),
    .bsr_wr(bsr_wr), .bsr_bit(bsr_bit), .bsr_val(bsr_val), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(rdata_b), .pd_in(pd_in),
    .pd_out(pdo_b), .pd_oe(pdoe_b), .pc_in(pcin_b), .pc_out(pcout_b), .pc_oe(pcoe_b));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_stb(logic v);
    pcin_a[4] = v;
    pcin_b[2] = v;
  endtask

  task automatic set_ack(logic v);
    pcin_a[6] = v;
    pcin_b[2] = v;
  endtask

  task automatic bsr(logic [2:0] b, logic v);
    bsr_wr = 1'b1; bsr_bit = b; bsr_val = v;
    tick();
    bsr_wr = 1'b0;
  endtask

  task automatic mode(logic din);
    mode_wr = 1'b1; mode_dir_in = din;
    tick();
    mode_wr = 1'b0;
  endtask

  task automatic rd();
    cpu_rd = 1'b1;
    tick();
    cpu_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state, R2 input-direction role map
    check("R1 a flags", {pcout_a[5], pcout_a[3], pdoe_a}, 8'h00);
    check("R1 b flags", {pcout_b[1], pcout_b[0], pdoe_b}, 8'h00);
    check("R1 a rdata", rdata_a, 8'h00);
    check("R2 a in oe", pcoe_a, 8'h28);
    check("R2 b in oe", pcoe_b, 8'h03);
    // R1 enable starts 0: a strobe gives no interrupt
    pd_in = 8'h5A; set_stb(1'b0); tick(); set_stb(1'b1); tick();
    check("R1 a no int", {7'd0, pcout_a[3]}, 8'h00);
    check("R1 b no int", {7'd0, pcout_b[0]}, 8'h00);
    rd();

    // R3 R4 R5 sweep over every byte
    for (int d = 0; d < 256; d++) begin
      logic en;
      en = d[0];
      bsr(3'd4, en);
      bsr(3'd2, en);
      pd_in = d[7:0];
      set_stb(1'b0); tick();
      pd_in = ~d[7:0];
      check("R3 a ibf", {7'd0, pcout_a[5]}, 8'h01);
      check("R3 b ibf", {7'd0, pcout_b[1]}, 8'h01);
      check("R3 a data", rdata_a, d[7:0]);
      check("R3 b data", rdata_b, d[7:0]);
      set_stb(1'b1); tick();
      check("R4 a int", {7'd0, pcout_a[3]}, {7'd0, en});
      check("R4 b int", {7'd0, pcout_b[0]}, {7'd0, en});
      rd();
      check("R5 a clr", {pcout_a[5], pcout_a[3]}, 8'h00);
      check("R5 b clr", {pcout_b[1], pcout_b[0]}, 8'h00);
    end

    // R9 only the enable bit acts
    for (int b = 0; b < 8; b++) begin
      mode(1'b1);
      bsr(b[2:0], 1'b1);
      set_stb(1'b0); tick(); set_stb(1'b1); tick();
      check("R9 a int", {7'd0, pcout_a[3]}, {7'd0, b == 4});
      check("R9 b int", {7'd0, pcout_b[0]}, {7'd0, b == 2});
      rd();
    end

    // R11 strobe low during read keeps the byte
    pd_in = 8'hC3; set_stb(1'b0); cpu_rd = 1'b1; tick(); cpu_rd = 1'b0; set_stb(1'b1);
    check("R11 a ibf", {7'd0, pcout_a[5]}, 8'h01);
    check("R11 b ibf", {7'd0, pcout_b[1]}, 8'h01);
    check("R11 a data", rdata_a, 8'hC3);
    tick();

    // R10 mode write clears a pending input flag; R2 output map
    mode(1'b0);
    check("R10 a pd_out", pdo_a, 8'h00);
    check("R6 a oe", {7'd0, pdoe_a}, 8'h01);
    check("R2 a out oe", pcoe_a, 8'h88);
    check("R2 b out oe", pcoe_b, 8'h03);
    check("R10 a obf", {7'd0, pcout_a[7]}, 8'h01);
    check("R10 b obf", {7'd0, pcout_b[1]}, 8'h01);

    // R6 R7 R8 sweep over every byte
    for (int d = 0; d < 256; d++) begin
      logic en;
      en = d[0];
      bsr(3'd6, en);
      bsr(3'd2, en);
      cpu_wr = 1'b1; cpu_wdata = d[7:0]; tick(); cpu_wr = 1'b0;
      check("R6 a data", pdo_a, d[7:0]);
      check("R6 b data", pdo_b, d[7:0]);
      check("R6 a obf int", {pcout_a[7], pcout_a[3]}, 8'h00);
      check("R6 b obf int", {pcout_b[1], pcout_b[0]}, 8'h00);
      set_ack(1'b0); tick();
      check("R7 a obf", {7'd0, pcout_a[7]}, 8'h01);
      check("R7 b obf", {7'd0, pcout_b[1]}, 8'h01);
      set_ack(1'b1); tick();
      check("R8 a int", {7'd0, pcout_a[3]}, {7'd0, en});
      check("R8 b int", {7'd0, pcout_b[0]}, {7'd0, en});
    end

    // R10 mode write mid-transfer clears flags, data and enable
    bsr(3'd6, 1'b1); bsr(3'd2, 1'b1);
    set_ack(1'b0); tick(); set_ack(1'b1); tick();
    cpu_wr = 1'b1; cpu_wdata = 8'hA5; tick(); cpu_wr = 1'b0;
    mode(1'b0);
    check("R10 a obf", {7'd0, pcout_a[7]}, 8'h01);
    check("R10 b pd_out", pdo_b, 8'h00);
    set_ack(1'b0); tick(); set_ack(1'b1); tick();
    check("R10 a inte", {7'd0, pcout_a[3]}, 8'h00);
    check("R10 b inte", {7'd0, pcout_b[0]}, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule